// File: doc/BRIEF.md
# Channel Edge Detector with Dead Time

This block sits behind one discriminated input channel. It watches a synchronous digital level and a free-running fine timestamp, and it turns the edges it is told to watch for into hit records. Each record carries the channel number, an edge-kind bit, a timestamp and, in pulse-pair operation, a measured width. There are four modes. Leading-only and trailing-only report one kind of edge. Both-edges reports each edge as its own record. Pair reports one record per pulse, holding the leading time and the scaled pulse length.

After an accepted edge the channel goes blind for a programmable interval, so that reflections on the input cable are not counted as new hits. The four interval settings (5, 10, 30 and 100 ns) become clock-cycle counts when the design is built, using the clock period parameter and rounding up. The output is a single-entry holding register with a valid/ready handshake. When a new record finds that register still occupied, the new record is discarded and a sticky overflow flag is raised.

Top module: `chan_edge_dt`

## Requirements
- R1: While reset is high and on the first cycle after it, `hit_valid` and `hit_ovf` are 0.
- R2: With `mode_sel` = 0 (leading), each accepted 0-to-1 transition of `sig_in` produces one record with `hit_edge` = 0 and `hit_time` equal to `ts_in` at the clock edge where the new level is first sampled; 1-to-0 transitions produce nothing.
- R3: With `mode_sel` = 1 (trailing), each accepted 1-to-0 transition produces one record with `hit_edge` = 1 and the falling-edge timestamp; rising transitions produce nothing.
- R4: With `mode_sel` = 2 (both), rising and falling transitions each produce a separate record (`hit_edge` 0 and 1 respectively), in the order in which they occur.
- R5: With `mode_sel` = 3 (pair), a pulse produces one record at its trailing edge, with `hit_edge` = 0, `hit_time` = leading timestamp and `hit_width` = ((trailing − leading) mod 2^TS_W) >> `wres_sel`; in the other modes `hit_width` is 0.
- R6: In pair mode, if a second accepted leading edge arrives while an earlier leading edge is still waiting for its trailing edge, the earlier pulse is discarded and never reported.
- R7: After an accepted edge (a record-producing edge in modes 0 to 2, or the leading edge in pair mode), all transitions sampled in the next D cycles are ignored. D = ceil(T / clock period), where T is 5, 10, 30 or 100 ns for `dead_sel` = 0, 1, 2 or 3. At the default 5 ns clock this gives D = 1, 2, 6 and 20.
- R8: While `hit_valid` is 1 and `hit_ready` is 0, the presented record stays unchanged.
- R9: A record that is created while the held record is not being taken is dropped, `hit_ovf` goes to 1 and stays 1 until reset, and the held record is still delivered.
- R10: `hit_chan` equals the `chan_id` value that was present when the record was created.
- R11: A record becomes visible on the cycle after its edge is sampled. If the held record is taken in the same cycle that a new record is created, the new record replaces it with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Discriminated channel level, synchronous to clk |
| ts_in | input | TS_W | Free-running fine timestamp |
| chan_id | input | CH_W | Channel number stamped into records |
| mode_sel | input | 2 | 0 leading, 1 trailing, 2 both, 3 pair |
| dead_sel | input | 2 | Blind interval: 0 = 5 ns, 1 = 10 ns, 2 = 30 ns, 3 = 100 ns |
| wres_sel | input | 2 | Right-shift applied to the pair width |
| hit_ready | input | 1 | Consumer accepts the held record |
| hit_valid | output | 1 | Held record is valid |
| hit_chan | output | CH_W | Record channel number |
| hit_edge | output | 1 | 0 leading or pair, 1 trailing |
| hit_time | output | TS_W | Record timestamp |
| hit_width | output | TS_W | Scaled pulse width (pair mode), else 0 |
| hit_ovf | output | 1 | Sticky flag: a record was dropped |

## Verification
Two things can happen in the same cycle: the consumer takes the held record, and a new edge creates a record. The bench first holds `hit_ready` low so that a record sits in the holding register. It then raises `hit_ready` on the same falling clock edge that drives the next rising transition of `sig_in`. The bench expects both records to arrive in order, with `hit_ovf` still 0. A separate run keeps `hit_ready` low through the second edge. There the bench expects the first record to be kept, the second to be lost, and the overflow flag to be set.

// File: rtl/ced_pkg.sv
package ced_pkg;

    typedef enum logic [1:0] {
        MODE_LEAD  = 2'd0,
        MODE_TRAIL = 2'd1,
        MODE_BOTH  = 2'd2,
        MODE_PAIR  = 2'd3
    } mode_e;

    localparam logic KIND_LEAD  = 1'b0;
    localparam logic KIND_TRAIL = 1'b1;

    // Blind interval in nanoseconds for each selector code.
    function automatic int unsigned blind_ns(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5;
            2'd1:    return 10;
            2'd2:    return 30;
            default: return 100;
        endcase
    endfunction

    // Interval converted to clock cycles, rounded up.
    function automatic int unsigned blind_cycles(input logic [1:0] sel,
                                                 input int unsigned clk_ps);
        return (blind_ns(sel) * 1000 + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/ced_edge_sense.sv
module ced_edge_sense (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig_in;
    end

    assign rise = sig_in & ~sig_q;
    assign fall = ~sig_in & sig_q;
endmodule

// File: rtl/ced_dead_timer.sv
module ced_dead_timer
    import ced_pkg::*;
#(
    parameter int unsigned CLK_PS = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] sel,
    output logic       blind
);
    localparam int unsigned MAX_CYC = blind_cycles(2'd3, CLK_PS);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] reload [4];
    logic [CNT_W-1:0] cnt_q;

    for (genvar g = 0; g < 4; g++) begin : g_reload
        assign reload[g] = CNT_W'(blind_cycles(2'(g), CLK_PS));
    end

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= reload[sel];
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign blind = (cnt_q != '0);
endmodule

// File: rtl/ced_pair_track.sv
module ced_pair_track #(
    parameter int unsigned TS_W   = 16,
    parameter int unsigned WRES_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              lead_ok,
    input  logic              trail_ok,
    input  logic [TS_W-1:0]   ts,
    input  logic [WRES_W-1:0] shift,
    output logic              done,
    output logic [TS_W-1:0]   done_time,
    output logic [TS_W-1:0]   done_width
);
    logic            pend_q;
    logic [TS_W-1:0] lead_ts_q;
    logic [TS_W-1:0] raw_width;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pend_q    <= 1'b0;
            lead_ts_q <= '0;
        end else if (lead_ok) begin
            // A newer leading edge replaces any unfinished pulse.
            pend_q    <= 1'b1;
            lead_ts_q <= ts;
        end else if (trail_ok && pend_q) begin
            pend_q    <= 1'b0;
        end
    end

    assign done       = en & trail_ok & pend_q;
    assign raw_width  = ts - lead_ts_q;
    assign done_time  = lead_ts_q;
    assign done_width = raw_width >> shift;
endmodule

// File: rtl/ced_out_skid.sv
module ced_out_skid #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         ovf
);
    logic full;
    assign full = out_valid & ~out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            ovf       <= 1'b0;
        end else if (in_valid) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                out_valid <= 1'b1;
                out_data  <= in_data;
            end
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/chan_edge_dt.sv
module chan_edge_dt
    import ced_pkg::*;
#(
    parameter int unsigned TS_W   = 16,
    parameter int unsigned CH_W   = 5,
    parameter int unsigned CLK_PS = 5000,
    parameter int unsigned WRES_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sig_in,
    input  logic [TS_W-1:0]   ts_in,
    input  logic [CH_W-1:0]   chan_id,
    input  logic [1:0]        mode_sel,
    input  logic [1:0]        dead_sel,
    input  logic [WRES_W-1:0] wres_sel,
    input  logic              hit_ready,
    output logic              hit_valid,
    output logic [CH_W-1:0]   hit_chan,
    output logic              hit_edge,
    output logic [TS_W-1:0]   hit_time,
    output logic [TS_W-1:0]   hit_width,
    output logic              hit_ovf
);
    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            kind;
        logic [TS_W-1:0] stamp;
        logic [TS_W-1:0] span;
    } rec_t;

    localparam int unsigned REC_W = $bits(rec_t);

    mode_e           mode;
    logic            rise, fall, blind;
    logic            rise_ok, fall_ok;
    logic            pair_en, pair_done;
    logic [TS_W-1:0] pair_time, pair_width;
    logic            new_rec, load_dead;
    rec_t            rec, held;
    logic [REC_W-1:0] held_bits;

    assign mode = mode_e'(mode_sel);

    ced_edge_sense u_sense (
        .clk (clk), .rst (rst), .sig_in (sig_in),
        .rise(rise), .fall(fall)
    );

    ced_dead_timer #(.CLK_PS(CLK_PS)) u_dead (
        .clk(clk), .rst(rst), .load(load_dead), .sel(dead_sel), .blind(blind)
    );

    assign rise_ok = rise & ~blind;
    assign fall_ok = fall & ~blind;
    assign pair_en = (mode == MODE_PAIR);

    ced_pair_track #(.TS_W(TS_W), .WRES_W(WRES_W)) u_pair (
        .clk(clk), .rst(rst), .en(pair_en),
        .lead_ok(rise_ok), .trail_ok(fall_ok),
        .ts(ts_in), .shift(wres_sel),
        .done(pair_done), .done_time(pair_time), .done_width(pair_width)
    );

    always_comb begin
        rec.chan  = chan_id;
        rec.kind  = KIND_LEAD;
        rec.stamp = ts_in;
        rec.span  = '0;
        new_rec   = 1'b0;
        load_dead = 1'b0;
        case (mode)
            MODE_LEAD: begin
                new_rec   = rise_ok;
                load_dead = rise_ok;
            end
            MODE_TRAIL: begin
                new_rec   = fall_ok;
                load_dead = fall_ok;
                rec.kind  = KIND_TRAIL;
            end
            MODE_BOTH: begin
                new_rec   = rise_ok | fall_ok;
                load_dead = rise_ok | fall_ok;
                rec.kind  = fall_ok ? KIND_TRAIL : KIND_LEAD;
            end
            default: begin
                new_rec   = pair_done;
                load_dead = rise_ok;
                rec.stamp = pair_time;
                rec.span  = pair_width;
            end
        endcase
    end

    ced_out_skid #(.W(REC_W)) u_skid (
        .clk(clk), .rst(rst),
        .in_valid(new_rec), .in_data(rec),
        .out_ready(hit_ready),
        .out_valid(hit_valid), .out_data(held_bits), .ovf(hit_ovf)
    );

    assign held      = rec_t'(held_bits);
    assign hit_chan  = held.chan;
    assign hit_edge  = held.kind;
    assign hit_time  = held.stamp;
    assign hit_width = held.span;
endmodule

// File: rtl/ced_checker.sv
module ced_checker #(
    parameter int unsigned TS_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            hit_valid,
    input logic            hit_ready,
    input logic            hit_edge,
    input logic [TS_W-1:0] hit_time,
    input logic [TS_W-1:0] hit_width,
    input logic            hit_ovf,
    input logic            blind
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!hit_valid && !hit_ovf));

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && !hit_ready) |=>
            (hit_valid && $stable(hit_time) && $stable(hit_width) && $stable(hit_edge)));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        hit_ovf |=> hit_ovf);

    p_ovf_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(hit_ovf) |-> $past(hit_valid && !hit_ready));

    p_blind_no_rec_r7: assert property (@(posedge clk) disable iff (rst)
        blind |=> !$rose(hit_valid));

    p_blind_no_ovf_r7: assert property (@(posedge clk) disable iff (rst)
        blind |=> !$rose(hit_ovf));
endmodule

bind chan_edge_dt ced_checker #(.TS_W(TS_W)) u_chk (
    .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .hit_edge(hit_edge), .hit_time(hit_time), .hit_width(hit_width),
    .hit_ovf(hit_ovf), .blind(blind)
);

// File: tb/sim_chan_edge_dt.sv
`timescale 1ns/1ps
module sim_chan_edge_dt;
    localparam int TS_W = 16;
    localparam int CH_W = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sig_in = 1'b0;
    logic [TS_W-1:0] ts_in = '0;
    logic [CH_W-1:0] chan_id = 5'h13;
    logic [1:0]      mode_sel = 2'd0;
    logic [1:0]      dead_sel = 2'd0;
    logic [1:0]      wres_sel = 2'd0;
    logic            hit_ready = 1'b1;
    logic            hit_valid, hit_edge, hit_ovf;
    logic [CH_W-1:0] hit_chan;
    logic [TS_W-1:0] hit_time, hit_width;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic [CH_W-1:0] ch;
        logic            e;
        logic [TS_W-1:0] t;
        logic [TS_W-1:0] w;
        string           req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) ts_in <= ts_in + 1'b1;

    chan_edge_dt u0 (
        .clk(clk), .rst(rst), .sig_in(sig_in), .ts_in(ts_in), .chan_id(chan_id),
        .mode_sel(mode_sel), .dead_sel(dead_sel), .wres_sel(wres_sel),
        .hit_ready(hit_ready), .hit_valid(hit_valid), .hit_chan(hit_chan),
        .hit_edge(hit_edge), .hit_time(hit_time), .hit_width(hit_width),
        .hit_ovf(hit_ovf)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input logic e, input logic [TS_W-1:0] t,
                        input logic [TS_W-1:0] w, input string req);
        exp_t x;
        x.ch = chan_id; x.e = e; x.t = t; x.w = w; x.req = req;
        exp_q.push_back(x);
    endtask

    // Drive a level on the falling edge; returns the stamp the design will see.
    task automatic drive(input logic v, output logic [TS_W-1:0] t);
        @(negedge clk);
        sig_in = v;
        t = ts_in;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor: pops an expectation for every handshake.
    always begin
        @(negedge clk);
        #1;
        if (!rst && hit_valid && hit_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R2", "unexpected record time", int'(hit_time), -1);
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                check(hit_chan == x.ch && hit_edge == x.e &&
                      hit_time == x.t && hit_width == x.w, x.req,
                      $sformatf("record ch=%0d e=%0d w=%0d time", hit_chan, hit_edge, hit_width),
                      int'(hit_time), int'(x.t));
                check(hit_chan == x.ch, "R10", "channel", int'(hit_chan), int'(x.ch));
            end
        end
    end

    // Two rising edges 'gap' cycles apart in leading mode.
    task automatic gap_test(input logic [1:0] sel, input int gap, input bit second);
        logic [TS_W-1:0] t0, t1, tx;
        dead_sel = sel;
        drive(1'b1, t0); push(1'b0, t0, '0, "R7");
        drive(1'b0, tx);
        idle(gap - 2);
        drive(1'b1, t1);
        if (second) push(1'b0, t1, '0, "R7");
        drive(1'b0, tx);
        idle(30);
    endtask

    initial begin
        logic [TS_W-1:0] ta, tb, tx;
        repeat (4) @(negedge clk);
        check(hit_valid == 1'b0, "R1", "valid in reset", hit_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(hit_valid == 1'b0 && hit_ovf == 1'b0, "R1", "valid/ovf after reset",
              {hit_valid, hit_ovf}, 0);
        idle(3);

        // R2 leading
        mode_sel = 2'd0;
        drive(1'b1, ta); push(1'b0, ta, '0, "R2");
        idle(4); drive(1'b0, tx); idle(6);

        // R3 trailing
        mode_sel = 2'd1;
        drive(1'b1, tx); idle(4);
        drive(1'b0, tb); push(1'b1, tb, '0, "R3");
        idle(6);

        // R4 both edges; R11 visibility latency checked directly
        mode_sel = 2'd2;
        drive(1'b1, ta); push(1'b0, ta, '0, "R4");
        @(negedge clk);
        check(hit_valid == 1'b1, "R11", "valid one cycle after edge", hit_valid, 1);
        idle(3);
        drive(1'b0, tb); push(1'b1, tb, '0, "R4");
        idle(6);

        // R7 reflection suppression in both mode: fall inside blind window
        dead_sel = 2'd2;
        drive(1'b1, ta); push(1'b0, ta, '0, "R7");
        idle(2); drive(1'b0, tx); idle(12);
        dead_sel = 2'd0;

        // R5 pair mode with several width codes
        chan_id = 5'h0A;
        mode_sel = 2'd3;
        wres_sel = 2'd0;
        drive(1'b1, ta); idle(8); drive(1'b0, tb);
        push(1'b0, ta, (tb - ta), "R5"); idle(6);
        wres_sel = 2'd2;
        drive(1'b1, ta); idle(12); drive(1'b0, tb);
        push(1'b0, ta, (tb - ta) >> 2, "R5"); idle(6);
        wres_sel = 2'd3;
        drive(1'b1, ta); idle(19); drive(1'b0, tb);
        push(1'b0, ta, (tb - ta) >> 3, "R5"); idle(6);

        // R6 pending pulse replaced: first fall lands in the blind window
        wres_sel = 2'd0;
        dead_sel = 2'd2;
        drive(1'b1, tx); idle(1); drive(1'b0, tx);
        idle(7); drive(1'b1, ta); idle(7); drive(1'b0, tb);
        push(1'b0, ta, (tb - ta), "R6"); idle(30);
        dead_sel = 2'd0;

        // R7 dead-window boundaries per selector
        mode_sel = 2'd0;
        gap_test(2'd0, 2, 1'b1);
        gap_test(2'd1, 2, 1'b0);
        gap_test(2'd1, 3, 1'b1);
        gap_test(2'd2, 6, 1'b0);
        gap_test(2'd2, 7, 1'b1);
        gap_test(2'd3, 20, 1'b0);
        gap_test(2'd3, 21, 1'b1);
        dead_sel = 2'd0;

        // R11 take and new record in the same cycle
        @(negedge clk); hit_ready = 1'b0;
        drive(1'b1, ta); push(1'b0, ta, '0, "R11");
        drive(1'b0, tx); idle(2);
        @(negedge clk); sig_in = 1'b1; hit_ready = 1'b1; tb = ts_in;
        push(1'b0, tb, '0, "R11");
        drive(1'b0, tx); idle(5);
        check(hit_ovf == 1'b0, "R11", "no overflow on same-cycle take", hit_ovf, 0);

        // R8/R9 hold and overflow
        @(negedge clk); hit_ready = 1'b0;
        drive(1'b1, ta); push(1'b0, ta, '0, "R9");
        drive(1'b0, tx); idle(3);
        check(hit_valid == 1'b1 && hit_time == ta, "R8", "held time", int'(hit_time), int'(ta));
        drive(1'b1, tb); drive(1'b0, tx); idle(2);
        check(hit_ovf == 1'b1, "R9", "overflow flag", hit_ovf, 1);
        check(hit_time == ta, "R9", "held record kept", int'(hit_time), int'(ta));
        @(negedge clk); hit_ready = 1'b1;
        idle(5);
        check(hit_valid == 1'b0, "R9", "dropped record absent", hit_valid, 0);
        check(hit_ovf == 1'b1, "R9", "overflow sticky", hit_ovf, 1);

        idle(5);
        check(exp_q.size() == 0, "R2", "missing records", exp_q.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule